// File: doc/BRIEF.md
# Burst DMA Ready Handshake Generator

This block drives the two active-low request lines that a DMA controller watches when a UART moves data in bursts. The transmit line asks for a burst of writes once the transmit FIFO has room for at least a programmed number of bytes. It stays asserted while the controller fills the FIFO and drops only when the FIFO is full. The receive line asks for a burst of reads once the receive FIFO has collected a programmed number of bytes, or as soon as a receive time-out is reported. It stays asserted while the controller drains the FIFO and drops when the FIFO is empty or when the receive FIFO reports an error.

Each line is therefore a set/clear flip-flop rather than a comparator. This hysteresis lets one request cover a whole burst instead of toggling after every byte. The FIFOs, the time-out counter and the error summary logic sit outside the block. Their fill counts and events arrive as inputs that are sampled on each rising clock edge.

Top module: `dma_rdy_gen`

## Requirements
- R1: While `rst_n` is low, and after it is released until a set condition is seen, `tx_rdy_n` and `rx_rdy_n` are both 1 (inactive).
- R2: `tx_rdy_n` becomes 0 on the edge after a cycle in which the free space (DEPTH minus `tx_fill`) is at least the effective transmit trigger and the FIFO is not full. The effective trigger is `tx_trig`, except that a value of 0 counts as 1.
- R3: `tx_rdy_n` becomes 1 on the edge after a cycle in which `tx_fill` >= DEPTH (FIFO full). This clear takes priority over any set condition.
- R4: When neither the transmit set condition nor the full condition holds, `tx_rdy_n` keeps its value.
- R5: `rx_rdy_n` becomes 0 on the edge after a cycle in which `rx_fill` is at least the effective receive trigger. The effective trigger is `rx_trig`, except that a value of 0 counts as 1.
- R6: `rx_rdy_n` becomes 0 on the edge after a cycle with `rx_timeout` = 1, even when `rx_fill` is below the trigger, unless a clear condition holds in that cycle.
- R7: `rx_rdy_n` becomes 1 on the edge after a cycle in which `rx_fill` = 0. This takes priority over the trigger and the time-out.
- R8: `rx_rdy_n` becomes 1 on the edge after a cycle with `rx_fifo_err` = 1. This takes priority over the trigger and the time-out.
- R9: When no receive set or clear condition holds, `rx_rdy_n` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_fill | input | 7 | Bytes currently held in the transmit FIFO (0..64) |
| tx_trig | input | 7 | Transmit trigger: free spaces that start a burst |
| rx_fill | input | 7 | Bytes currently held in the receive FIFO (0..64) |
| rx_trig | input | 7 | Receive trigger: bytes held that start a burst |
| rx_timeout | input | 1 | Receive time-out event, one cycle or longer |
| rx_fifo_err | input | 1 | Error summary flag for data in the receive FIFO |
| tx_rdy_n | output | 1 | Transmit DMA request, active low |
| rx_rdy_n | output | 1 | Receive DMA request, active low |

## Verification
Both request lines come from one register each, so every response is due exactly one rising edge after the inputs that cause it. The bench changes inputs on the falling edge. On the next falling edge it compares the outputs with a reference state, which it advances by one step from the inputs it drove half a cycle before the edge. Because inputs and samples never share an edge, each check sees the single register update it is meant to see. It also covers the cases where a set and a clear condition arrive together.

// File: rtl/dma_rdy_pkg.sv
package dma_rdy_pkg;

  // Trigger value of zero behaves like a trigger of one.
  function automatic int eff_trig(input int trig);
    return (trig < 1) ? 1 : trig;
  endfunction

  // Free locations in a FIFO of the given depth; an over-range fill means none.
  function automatic int free_slots(input int depth, input int fill);
    return (fill >= depth) ? 0 : depth - fill;
  endfunction

  function automatic logic is_full(input int depth, input int fill);
    return fill >= depth;
  endfunction

endpackage

// File: rtl/rdy_latch.sv
module rdy_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr_ev,
  output logic rdy_n
);

  always_ff @(posedge clk) begin
    if (!rst_n)      rdy_n <= 1'b1;
    else if (clr_ev) rdy_n <= 1'b1;
    else if (set_ev) rdy_n <= 1'b0;
  end

  // R3 R7 R8
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ev |=> rdy_n);

  // R2 R5 R6
  set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_ev && !clr_ev) |=> !rdy_n);

  // R4 R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_ev && !clr_ev) |=> $stable(rdy_n));

endmodule

// File: rtl/tx_rdy_path.sv
module tx_rdy_path
  import dma_rdy_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CW    = 7
) (
  input  logic [CW-1:0] fill,
  input  logic [CW-1:0] trig,
  output logic          set_ev,
  output logic          clr_ev
);

  int free_n;
  int trig_n;

  always_comb begin
    free_n = free_slots(DEPTH, int'(fill));
    trig_n = eff_trig(int'(trig));
    clr_ev = is_full(DEPTH, int'(fill));
    set_ev = (free_n >= trig_n);
  end

endmodule

// File: rtl/rx_rdy_path.sv
module rx_rdy_path
  import dma_rdy_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic [CW-1:0] fill,
  input  logic [CW-1:0] trig,
  input  logic          timeout,
  input  logic          fifo_err,
  output logic          set_ev,
  output logic          clr_ev
);

  logic level_hit;
  logic empty;

  always_comb begin
    level_hit = (int'(fill) >= eff_trig(int'(trig)));
    empty     = (fill == '0);
    set_ev    = level_hit | timeout;
    clr_ev    = empty | fifo_err;
  end

endmodule

// File: rtl/dma_rdy_gen.sv
module dma_rdy_gen #(
  parameter  int DEPTH = 64,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] tx_fill,
  input  logic [CW-1:0] tx_trig,
  input  logic [CW-1:0] rx_fill,
  input  logic [CW-1:0] rx_trig,
  input  logic          rx_timeout,
  input  logic          rx_fifo_err,
  output logic          tx_rdy_n,
  output logic          rx_rdy_n
);

  logic tx_set, tx_clr, rx_set, rx_clr;

  tx_rdy_path #(.DEPTH(DEPTH), .CW(CW)) u_tx_path (
    .fill(tx_fill), .trig(tx_trig), .set_ev(tx_set), .clr_ev(tx_clr)
  );

  rx_rdy_path #(.CW(CW)) u_rx_path (
    .fill(rx_fill), .trig(rx_trig), .timeout(rx_timeout),
    .fifo_err(rx_fifo_err), .set_ev(rx_set), .clr_ev(rx_clr)
  );

  rdy_latch u_tx_latch (
    .clk(clk), .rst_n(rst_n), .set_ev(tx_set), .clr_ev(tx_clr), .rdy_n(tx_rdy_n)
  );

  rdy_latch u_rx_latch (
    .clk(clk), .rst_n(rst_n), .set_ev(rx_set), .clr_ev(rx_clr), .rdy_n(rx_rdy_n)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (tx_rdy_n && rx_rdy_n));

  // R3
  tx_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(tx_fill) >= DEPTH) |=> tx_rdy_n);

  // R8
  rx_err_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fifo_err |=> rx_rdy_n);

  // R7
  rx_empty_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fill == '0) |=> rx_rdy_n);

  // R6
  rx_timeout_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_timeout && !rx_fifo_err && rx_fill != '0) |=> !rx_rdy_n);

endmodule

// File: tb/test_dma_rdy_gen.sv
module test_dma_rdy_gen;

  localparam int DEPTH = 64;
  localparam int CW    = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] tx_fill = '0, tx_trig = '0, rx_fill = '0, rx_trig = '0;
  logic          rx_timeout = 1'b0, rx_fifo_err = 1'b0;
  logic          tx_rdy_n, rx_rdy_n;

  int  checks = 0;
  int  errors = 0;
  int  cycles = 0;
  bit  done   = 0;
  bit  m_tx = 1'b1, m_rx = 1'b1;
  string tx_tag = "R1", rx_tag = "R1";

  always #10 clk = ~clk;

  dma_rdy_gen #(.DEPTH(DEPTH)) i_dma_rdy_gen (
    .clk(clk), .rst_n(rst_n), .tx_fill(tx_fill), .tx_trig(tx_trig),
    .rx_fill(rx_fill), .rx_trig(rx_trig), .rx_timeout(rx_timeout),
    .rx_fifo_err(rx_fifo_err), .tx_rdy_n(tx_rdy_n), .rx_rdy_n(rx_rdy_n)
  );

  function automatic int need(input int t);
    if (t == 0) return 1;
    return t;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Called at a falling edge: check outputs, then apply stimulus and
  // advance the model to the state due after the next rising edge.
  task automatic step(input int tf, input int tt, input int rf, input int rt,
                      input bit to, input bit er);
    check(tx_tag, tx_rdy_n, m_tx);
    check(rx_tag, rx_rdy_n, m_rx);
    tx_fill = CW'(tf); tx_trig = CW'(tt); rx_fill = CW'(rf); rx_trig = CW'(rt);
    rx_timeout = to; rx_fifo_err = er;
    if (!rst_n) begin
      m_tx = 1; m_rx = 1; tx_tag = "R1"; rx_tag = "R1";
    end else begin
      if (tf >= DEPTH)                 begin m_tx = 1; tx_tag = "R3"; end
      else if (DEPTH - tf >= need(tt)) begin m_tx = 0; tx_tag = "R2"; end
      else                                 tx_tag = "R4";
      if (er)                          begin m_rx = 1; rx_tag = "R8"; end
      else if (rf == 0)                begin m_rx = 1; rx_tag = "R7"; end
      else if (rf >= need(rt))         begin m_rx = 0; rx_tag = "R5"; end
      else if (to)                     begin m_rx = 0; rx_tag = "R6"; end
      else                                 rx_tag = "R9";
    end
    @(negedge clk);
    cycles++;
  endtask

  function automatic int pick_fill(input int trig);
    int r;
    r = int'($urandom % 8);
    case (r)
      0: return 0;
      1: return DEPTH;
      2: return (trig > 0) ? trig - 1 : 0;
      3: return DEPTH - need(trig);
      default: return int'($urandom % (DEPTH + 1));
    endcase
  endfunction

  initial begin
    int tt, rt;
    void'($urandom(32'd1357));
    @(negedge clk);
    // R1: reset holds both lines inactive whatever the inputs
    step(0, 8, 40, 8, 1, 0);
    step(0, 8, 40, 8, 1, 0);
    rst_n = 1'b1;
    // R1: idle-neutral inputs after release keep lines inactive
    step(10, 60, 0, 8, 0, 0);
    step(10, 60, 0, 8, 0, 0);
    // R2 then R4 hold, then R3 full clears, then R4 holds high
    step(40, 16, 0, 8, 0, 0);
    step(60, 16, 0, 8, 0, 0);
    step(64, 16, 0, 8, 0, 0);
    step(60, 16, 0, 8, 0, 0);
    // R2 trigger of zero counts as one; R3 beats the set
    step(63, 0, 0, 8, 0, 0);
    step(64, 0, 0, 8, 0, 0);
    // R5 level reach, R9 hold below trigger, R7 empty
    step(0, 8, 8, 8, 0, 0);
    step(0, 8, 3, 8, 0, 0);
    step(0, 8, 0, 8, 0, 0);
    step(0, 8, 3, 8, 0, 0);
    // R6 time-out below trigger, R8 error beats timeout and level
    step(0, 8, 2, 32, 1, 0);
    step(0, 8, 2, 32, 0, 0);
    step(0, 8, 50, 32, 1, 1);
    step(0, 8, 1, 0, 0, 0);
    // R7 empty beats timeout
    step(0, 8, 0, 8, 1, 0);
    step(0, 8, 0, 8, 0, 0);
    // constrained random
    for (int blk = 0; blk < 40; blk++) begin
      tt = (blk % 3 == 0) ? int'($urandom % (DEPTH + 1)) : (1 << ($urandom % 7));
      rt = (blk % 4 == 0) ? 0 : int'($urandom % (DEPTH + 1));
      for (int k = 0; k < 50; k++)
        step(pick_fill(tt), tt, pick_fill(rt), rt,
             ($urandom % 8) == 0, ($urandom % 16) == 0);
    end
    step(0, 8, 0, 8, 0, 0);
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

endmodule